// File: doc/BRIEF.md
# SPI Digital Potentiometer Command Controller

This block is a serial-peripheral slave that sets an 8-bit wiper code and keeps a small bank of four retained 8-bit registers. A host selects the block with an active-low chip select and sends an identification byte, an instruction byte and, for some commands, a data byte. The commands read or write the wiper, read or write a bank register, copy a register into the wiper or the wiper into a register, step the wiper up or down one code per serial bit, and read a status byte. The wiper code is a digital output only. It would drive the tap switches of a resistor ladder elsewhere on the chip.

The serial pins are oversampled in the system clock domain through synchronizer stages. The serial timing is mode 0: the host changes MOSI while SCK is low and the block samples it on the SCK rising edge. The block changes MISO after the SCK falling edge. Bank storage keeps its contents through a reset, which stands in for a power cycle. When reset is released, register 0 is copied into the wiper. Committing a value to the bank starts a fixed-length store interval, and the block rejects changes while that interval runs.

Top module: `dpot_ctrl`

## Requirements
- R1: While chip select is high, or during reset, `spi_miso_oe` is low.
- R2: After reset, chip select must be seen high and then go low before a frame is decoded. Bytes clocked while chip select stayed low from reset have no effect.
- R3: The first byte of a frame is the ID byte. Bits [7:4] must be 4'b0101, bits [3:2] must be 2'b00 and bits [1:0] must equal `dev_addr`. Otherwise the rest of the frame is ignored.
- R4: The instruction byte carries an opcode in bits [7:4], a register select in bits [1:0], and bits [3:2] that must be zero, or the frame is ignored. The opcodes are 0x2 step, 0x5 status read, 0x9 wiper read, 0xA wiper write, 0xB register read, 0xC register write, 0xD register-to-wiper copy and 0xE wiper-to-register copy.
- R5: When reset is released, the wiper takes the value of bank register 0. The bank keeps its contents across reset.
- R6: For a read command (wiper, register or status), the third byte of the frame is driven on `spi_miso`, MSB first, one bit per SCK cycle.
- R7: A wiper write takes effect once the eighth data bit is received. A register write is committed when chip select rises, and only if all eight data bits arrived.
- R8: A register-to-wiper copy loads the wiper at the end of the instruction byte. A wiper-to-register copy commits the wiper value at chip select rise.
- R9: After a step instruction, each further bit until chip select rises moves the wiper one code: a 1 moves it up and a 0 moves it down. The wiper saturates at 0 and 255 and never wraps.
- R10: Each bank commit raises `store_busy` for STORE_CYCLES clocks. Bit 0 of the status byte is that flag; the other bits are zero.
- R11: A modifying command (0x2, 0xA, 0xC, 0xD, 0xE) decoded while `store_busy` is high is ignored.
- R12: While `wp_n` is low, the modifying commands are ignored. Reads still work.
- R13: While `spi_hold_n` is low, SCK edges are ignored, the frame state is kept and `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_hold_n | input | 1 | Active-low pause of the serial transfer |
| wp_n | input | 1 | Active-low write protect |
| dev_addr | input | 2 | Strapped device address compared with ID bits [1:0] |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| wiper | output | 8 | Current wiper code |
| store_busy | output | 1 | Store interval in progress |

## Verification
Two events can meet at one decision point: the store interval started by one frame, and a modifying command decoded in the next frame. The bench starts a frame right after a register commit, so that the instruction byte lands well inside the busy window. Its model judges each command from the time the instruction completed and the recorded commit time, and compares the wiper on every idle clock. A status read issued in the same window must report bit 0 set. The same read repeated after the window must report it clear.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b0101;

  typedef enum logic [3:0] {
    OP_STEP       = 4'h2,
    OP_STATUS     = 4'h5,
    OP_RD_WIPER   = 4'h9,
    OP_WR_WIPER   = 4'hA,
    OP_RD_BANK    = 4'hB,
    OP_WR_BANK    = 4'hC,
    OP_BANK2WIPER = 4'hD,
    OP_WIPER2BANK = 4'hE
  } op_e;

  typedef enum logic [2:0] {
    S_OFF, S_ID, S_INS, S_DATA, S_STEP, S_SKIP
  } fsm_e;
endpackage

// File: rtl/dpot_spi_rx.sv
module dpot_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       hold_n,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       frame_start,
  output logic       frame_end,
  output logic       bit_stb,
  output logic       bit_val,
  output logic       byte_stb,
  output logic [7:0] byte_val,
  output logic       miso,
  output logic       miso_oe
);
  localparam int CNT_W = 3;

  logic [SYNC_STAGES-1:0] sck_sr, cs_sr, mosi_sr, hold_sr;
  logic sck_s, cs_s, mosi_s, hold_s;
  logic sck_q, cs_q;
  logic active, rise, fall;
  logic [CNT_W-1:0] cnt;
  logic [6:0] shreg;
  logic [7:0] txsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sr  <= '0;
      cs_sr   <= '0;
      mosi_sr <= '0;
      hold_sr <= '1;
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
    end else begin
      sck_sr  <= {sck_sr[SYNC_STAGES-2:0], sck};
      cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
      hold_sr <= {hold_sr[SYNC_STAGES-2:0], hold_n};
      sck_q   <= sck_s;
      cs_q    <= cs_s;
    end
  end

  assign sck_s  = sck_sr[SYNC_STAGES-1];
  assign cs_s   = cs_sr[SYNC_STAGES-1];
  assign mosi_s = mosi_sr[SYNC_STAGES-1];
  assign hold_s = hold_sr[SYNC_STAGES-1];

  assign frame_start = cs_q & ~cs_s;
  assign frame_end   = ~cs_q & cs_s;
  assign active      = ~cs_s & hold_s;
  assign rise        = active & sck_s & ~sck_q;
  assign fall        = active & ~sck_s & sck_q;

  assign bit_stb  = rise;
  assign bit_val  = mosi_s;
  assign byte_stb = rise & (cnt == CNT_W'(7));
  assign byte_val = {shreg, mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      shreg   <= '0;
      txsr    <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= active;
      if (frame_start) begin
        cnt  <= '0;
        txsr <= '0;
        miso <= 1'b0;
      end else begin
        if (rise) begin
          cnt   <= cnt + 1'b1;
          shreg <= {shreg[5:0], mosi_s};
        end
        if (tx_load) begin
          txsr <= tx_byte;
        end else if (fall) begin
          miso <= txsr[7];
          txsr <= {txsr[6:0], 1'b0};
        end
      end
    end
  end

  a_r1_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !miso_oe);

  a_r13_hold_freezes_count: assert property (@(posedge clk) disable iff (rst)
    (!hold_s && !frame_start) |=> ($stable(cnt) && $stable(shreg)));
endmodule

// File: rtl/dpot_bank.sv
module dpot_bank #(
  parameter int N_REGS = 4,
  parameter int W      = 8,
  parameter logic [N_REGS*W-1:0] INIT = '0
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [$clog2(N_REGS)-1:0] waddr,
  input  logic [W-1:0]              wdata,
  input  logic [$clog2(N_REGS)-1:0] raddr,
  output logic [W-1:0]              rdata,
  output logic [W-1:0]              rdata0
);
  logic [W-1:0] mem [N_REGS];

  initial begin
    for (int i = 0; i < N_REGS; i++) mem[i] = INIT[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata  = mem[raddr];
  assign rdata0 = mem[0];
endmodule

// File: rtl/dpot_store_timer.sv
module dpot_store_timer #(
  parameter int CYCLES = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (start) begin
      cnt  <= CW'(CYCLES);
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
      busy <= (cnt != CW'(1));
    end
  end

  a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r11_no_restart_while_busy: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl #(
  parameter int N_REGS       = 4,
  parameter int STORE_CYCLES = 500,
  parameter int SYNC_STAGES  = 2,
  parameter logic [N_REGS*dpot_pkg::BYTE_W-1:0] BANK_INIT = 32'h4030_2080
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  input  logic       spi_hold_n,
  input  logic       wp_n,
  input  logic [1:0] dev_addr,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic [7:0] wiper,
  output logic       store_busy
);
  import dpot_pkg::*;
  localparam int SELW = $clog2(N_REGS);
  localparam logic [BYTE_W-1:0] WMAX = {BYTE_W{1'b1}};

  logic frame_start, frame_end, bit_stb, bit_val, byte_stb;
  logic [7:0] byte_val;
  logic tx_load;
  logic [7:0] tx_byte;
  logic [1:0] wp_sr;
  logic mod_ok;

  fsm_e state;
  logic [3:0] op_q;
  logic [SELW-1:0] pend_sel;
  logic [BYTE_W-1:0] pend_data, wiper_q, bank_rdata, bank_rdata0;
  logic pend_store, recall_pend;

  logic [3:0] ins_op;
  logic [SELW-1:0] ins_sel;
  logic ins_rsv_ok, id_ok, decode, ins_valid, is_read, bank_we;

  dpot_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .hold_n(spi_hold_n), .tx_load(tx_load), .tx_byte(tx_byte),
    .frame_start(frame_start), .frame_end(frame_end), .bit_stb(bit_stb),
    .bit_val(bit_val), .byte_stb(byte_stb), .byte_val(byte_val),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  dpot_bank #(.N_REGS(N_REGS), .W(BYTE_W), .INIT(BANK_INIT)) u_bank (
    .clk(clk), .we(bank_we), .waddr(pend_sel), .wdata(pend_data),
    .raddr(ins_sel), .rdata(bank_rdata), .rdata0(bank_rdata0)
  );

  dpot_store_timer #(.CYCLES(STORE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(bank_we), .busy(store_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) wp_sr <= 2'b00;
    else     wp_sr <= {wp_sr[0], wp_n};
  end

  assign mod_ok = wp_sr[1] & ~store_busy;

  always_comb begin
    ins_op     = byte_val[7:4];
    ins_sel    = byte_val[SELW-1:0];
    ins_rsv_ok = (byte_val[3:SELW] == '0);
    id_ok      = (byte_val[7:4] == DEV_TYPE) && (byte_val[3:2] == 2'b00) &&
                 (byte_val[1:0] == dev_addr);
    decode     = (state == S_INS) && byte_stb && !frame_start;
    ins_valid  = decode && ins_rsv_ok;
    is_read    = (ins_op == OP_RD_WIPER) || (ins_op == OP_RD_BANK) ||
                 (ins_op == OP_STATUS);
    tx_load    = ins_valid && is_read;
    bank_we    = frame_end && pend_store;
    case (ins_op)
      OP_RD_WIPER: tx_byte = wiper_q;
      OP_RD_BANK:  tx_byte = bank_rdata;
      default:     tx_byte = {7'b0, store_busy};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_OFF;
      op_q        <= 4'h0;
      wiper_q     <= '0;
      recall_pend <= 1'b1;
      pend_store  <= 1'b0;
      pend_sel    <= '0;
      pend_data   <= '0;
    end else begin
      if (recall_pend) begin
        wiper_q     <= bank_rdata0;
        recall_pend <= 1'b0;
      end
      if (frame_end) begin
        pend_store <= 1'b0;
        state      <= S_OFF;
      end else if (frame_start) begin
        pend_store <= 1'b0;
        state      <= S_ID;
      end else begin
        case (state)
          S_ID: if (byte_stb) state <= id_ok ? S_INS : S_SKIP;
          S_INS: if (byte_stb) begin
            op_q  <= ins_op;
            state <= S_SKIP;
            if (ins_rsv_ok) begin
              case (ins_op)
                OP_RD_WIPER, OP_RD_BANK, OP_STATUS: state <= S_DATA;
                OP_WR_WIPER, OP_WR_BANK: if (mod_ok) begin
                  state    <= S_DATA;
                  pend_sel <= ins_sel;
                end
                OP_BANK2WIPER: if (mod_ok) wiper_q <= bank_rdata;
                OP_WIPER2BANK: if (mod_ok) begin
                  pend_store <= 1'b1;
                  pend_data  <= wiper_q;
                  pend_sel   <= ins_sel;
                end
                OP_STEP: if (mod_ok) state <= S_STEP;
                default: state <= S_SKIP;
              endcase
            end
          end
          S_DATA: if (byte_stb) begin
            state <= S_SKIP;
            if (op_q == OP_WR_WIPER) wiper_q <= byte_val;
            if (op_q == OP_WR_BANK) begin
              pend_store <= 1'b1;
              pend_data  <= byte_val;
            end
          end
          S_STEP: if (bit_stb) begin
            if (bit_val && wiper_q != WMAX)     wiper_q <= wiper_q + 1'b1;
            else if (!bit_val && wiper_q != '0) wiper_q <= wiper_q - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign wiper = wiper_q;

  a_r9_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (state == S_STEP && bit_stb && bit_val && wiper_q == WMAX && !frame_start)
    |=> wiper_q == WMAX);

  a_r9_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (state == S_STEP && bit_stb && !bit_val && wiper_q == '0 && !frame_start)
    |=> wiper_q == '0);

  a_r3_bad_id_skips: assert property (@(posedge clk) disable iff (rst)
    (state == S_ID && byte_stb && !frame_start && byte_val[7:4] != DEV_TYPE)
    |=> state == S_SKIP);

  a_r12_no_step_when_protected: assert property (@(posedge clk) disable iff (rst)
    (decode && !wp_sr[1]) |=> state != S_STEP);
endmodule

// File: tb/tb_dpot_ctrl.sv
module tb_dpot_ctrl;
  localparam int STORE = 300;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic [1:0] dev_addr = 2'b10;
  logic miso, miso_oe, busy;
  logic [7:0] wiper;

  dpot_ctrl #(.STORE_CYCLES(STORE)) dut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .wp_n(wp_n), .dev_addr(dev_addr),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .wiper(wiper), .store_busy(busy)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit cmp_en = 0;
  logic [7:0] m_wiper = 8'h80;
  logic [7:0] m_bank [4] = '{8'h80, 8'h20, 8'h30, 8'h40};
  int store_cyc = -100000;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !rst) chk(wiper === m_wiper, "R7 wiper vs model", wiper, m_wiper);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic spi_bit(input logic b, output logic r);
    mosi = b;
    tick(HALF);
    r = miso;
    sck = 1'b1;
    tick(HALF);
    sck = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) spi_bit(b[i], r[i]);
  endtask

  task automatic model_apply(input logic [7:0] id, input logic [7:0] ins, input bit has_data,
                             input logic [7:0] data, input int nstep, input logic [31:0] bits,
                             input int ins_c, input int up_c);
    bit mod;
    if (id[7:4] != 4'h5 || id[3:2] != 2'b00 || id[1:0] != dev_addr) return;
    if (ins[3:2] != 2'b00) return;
    mod = wp_n && ((ins_c - store_cyc) >= STORE);
    if (!mod) return;
    case (ins[7:4])
      4'hA: if (has_data) m_wiper = data;
      4'hC: if (has_data) begin m_bank[ins[1:0]] = data; store_cyc = up_c; end
      4'hD: m_wiper = m_bank[ins[1:0]];
      4'hE: begin m_bank[ins[1:0]] = m_wiper; store_cyc = up_c; end
      4'h2: for (int i = 0; i < nstep; i++) begin
        if (bits[i] && m_wiper != 8'hFF) m_wiper++;
        else if (!bits[i] && m_wiper != 8'h00) m_wiper--;
      end
      default: ;
    endcase
  endtask

  task automatic frame(input logic [7:0] id, input logic [7:0] ins, input bit has_data,
                       input logic [7:0] data, input int nstep, input logic [31:0] bits,
                       output logic [7:0] rd);
    logic [7:0] r;
    logic r0;
    int ins_c, up_c;
    cmp_en = 0;
    cs_n = 1'b0;
    tick(HALF);
    spi_byte(id, r);
    spi_byte(ins, r);
    ins_c = cyc;
    rd = 8'h00;
    if (has_data) spi_byte(data, rd);
    for (int i = 0; i < nstep; i++) spi_bit(bits[i], r0);
    tick(HALF);
    cs_n = 1'b1;
    up_c = cyc;
    tick(2 * HALF);
    model_apply(id, ins, has_data, data, nstep, bits, ins_c, up_c);
    cmp_en = 1;
  endtask

  logic [7:0] rd, junk;

  initial begin
    tick(5);
    chk(miso_oe == 1'b0, "R1 oe in reset", miso_oe, 0);
    chk(busy == 1'b0, "R10 busy in reset", busy, 0);
    rst = 1'b0;
    tick(4);
    chk(wiper == 8'h80, "R5 recall at power-up", wiper, 8'h80);
    // R2: chip select low since reset; a write must be ignored
    spi_byte(8'h52, junk); spi_byte(8'hA0, junk); spi_byte(8'h11, junk);
    tick(HALF); cs_n = 1'b1; tick(2 * HALF);
    chk(wiper == 8'h80, "R2 no frame before cs high", wiper, 8'h80);
    chk(miso_oe == 1'b0, "R1 oe deselected", miso_oe, 0);
    cmp_en = 1;

    frame(8'h52, 8'hA0, 1, 8'h5A, 0, 0, rd);
    chk(wiper == 8'h5A, "R7 wiper write", wiper, 8'h5A);
    frame(8'h52, 8'h90, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'h5A, "R6 wiper read", rd, 8'h5A);
    frame(8'h52, 8'hB2, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'h30, "R6 R4 bank2 read", rd, 8'h30);
    frame(8'h51, 8'hA0, 1, 8'h22, 0, 0, rd);
    chk(wiper == 8'h5A, "R3 address mismatch", wiper, 8'h5A);
    frame(8'h62, 8'hA0, 1, 8'h22, 0, 0, rd);
    chk(wiper == 8'h5A, "R3 type mismatch", wiper, 8'h5A);
    frame(8'h52, 8'hA4, 1, 8'h22, 0, 0, rd);
    chk(wiper == 8'h5A, "R4 reserved bits set", wiper, 8'h5A);

    frame(8'h52, 8'hC1, 1, 8'hC3, 0, 0, rd);
    chk(busy == 1'b1, "R10 busy after commit", busy, 1);
    frame(8'h52, 8'h50, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'h01, "R10 status during store", rd, 1);
    tick(STORE + 100);
    chk(busy == 1'b0, "R10 busy clears", busy, 0);
    frame(8'h52, 8'h50, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'h00, "R10 status idle", rd, 0);
    frame(8'h52, 8'hB1, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'hC3, "R7 bank commit", rd, 8'hC3);

    frame(8'h52, 8'hC3, 1, 8'h77, 0, 0, rd);
    frame(8'h52, 8'hA0, 1, 8'h99, 0, 0, rd);
    chk(wiper == 8'h5A, "R11 write while busy", wiper, 8'h5A);
    tick(STORE + 100);
    frame(8'h52, 8'hB3, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'h77, "R7 bank3 commit", rd, 8'h77);

    frame(8'h52, 8'hD1, 0, 8'h00, 0, 0, rd);
    chk(wiper == 8'hC3, "R8 bank to wiper", wiper, 8'hC3);
    frame(8'h52, 8'hA0, 1, 8'h19, 0, 0, rd);
    frame(8'h52, 8'hE0, 0, 8'h00, 0, 0, rd);
    tick(STORE + 100);
    frame(8'h52, 8'hB0, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'h19, "R8 wiper to bank0", rd, 8'h19);

    frame(8'h52, 8'hA0, 1, 8'hFD, 0, 0, rd);
    frame(8'h52, 8'h20, 0, 8'h00, 7, 32'b0011111, rd);
    chk(wiper == 8'hFD, "R9 saturate high", wiper, 8'hFD);
    frame(8'h52, 8'hA0, 1, 8'h02, 0, 0, rd);
    frame(8'h52, 8'h20, 0, 8'h00, 5, 32'b10000, rd);
    chk(wiper == 8'h01, "R9 saturate low", wiper, 8'h01);

    wp_n = 1'b0;
    tick(4);
    frame(8'h52, 8'hA0, 1, 8'h44, 0, 0, rd);
    chk(wiper == 8'h01, "R12 protected write", wiper, 8'h01);
    frame(8'h52, 8'h20, 0, 8'h00, 3, 32'b111, rd);
    chk(wiper == 8'h01, "R12 protected step", wiper, 8'h01);
    frame(8'h52, 8'hC2, 1, 8'h55, 0, 0, rd);
    chk(busy == 1'b0, "R12 no store when protected", busy, 0);
    frame(8'h52, 8'hB2, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'h30, "R12 read while protected", rd, 8'h30);
    wp_n = 1'b1;
    tick(4);

    frame(8'h52, 8'hC2, 0, 8'h00, 4, 32'b1111, rd);
    chk(busy == 1'b0, "R7 partial data no store", busy, 0);
    frame(8'h52, 8'hB2, 1, 8'h00, 0, 0, rd);
    chk(rd == 8'h30, "R7 partial data bank kept", rd, 8'h30);

    // R13: hold pauses the frame between ID and instruction
    cmp_en = 0;
    cs_n = 1'b0; tick(HALF);
    spi_byte(8'h52, junk);
    hold_n = 1'b0; tick(HALF);
    chk(miso_oe == 1'b0, "R13 oe off in hold", miso_oe, 0);
    spi_byte(8'hFF, junk);
    hold_n = 1'b1; tick(HALF);
    chk(miso_oe == 1'b1, "R13 oe back after hold", miso_oe, 1);
    spi_byte(8'hA0, junk); spi_byte(8'h6B, junk);
    tick(HALF); cs_n = 1'b1; tick(2 * HALF);
    m_wiper = 8'h6B;
    chk(wiper == 8'h6B, "R13 frame kept across hold", wiper, 8'h6B);
    cmp_en = 1;

    frame(8'h52, 8'hC0, 1, 8'h3C, 0, 0, rd);
    tick(STORE + 100);
    cmp_en = 0;
    rst = 1'b1; tick(3);
    rst = 1'b0; tick(4);
    m_wiper = 8'h3C;
    chk(wiper == 8'h3C, "R5 recall keeps bank", wiper, 8'h3C);
    cmp_en = 1;
    tick(10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule